// File: doc/BRIEF.md
# Multi-Line Write Header Sequencer

This block takes one write command and issues a run of 80-bit transmit headers, one for each 64-byte line. A command can cover one, two or four lines. It carries a line-granular address, a length code, a write request type, a virtual channel, a metadata tag and an optional byte-access setting. The first header of a run is complete. Each header after it is a reduced form that carries only the request type and the position of the line within the run. Every other bit of the reduced form is driven to zero.

Commands enter through a valid/ready handshake, and headers leave through a second one. The block captures the command when it accepts it. It then holds the command side closed until the downstream side has taken the last header of the run. The block checks each command before it starts. A command with a bad length code, a misaligned address, byte access combined with a multi-line length, or an unsupported request type produces no header. Such a command raises a one-cycle error pulse instead.

Top module: `wr_hdr_seq`

## Requirements
- R1: After reset, `hdr_valid` and `cmd_err` are 0 and `cmd_ready` is 1.
- R2: A legal command with length code 2'b00 produces 1 header, 2'b01 produces 2 and 2'b11 produces 4. After the last of these is handed off, `cmd_ready` returns to 1.
- R3: The first header has bit 71 = 1, [73:72] = virtual channel, [69:68] = length code, [67:64] = request type, [57:16] = line address and [15:0] = metadata. Bit 70 is 1 for byte access and 0 for line access. [79:74] holds the byte count and [63:58] holds the byte offset.
- R4: Every later header has bit 71 = 0 and [67:64] = request type. Bits [17:16] equal the low two address bits of that line, which is the base address low bits plus the beat number, modulo 4. All other bits are 0.
- R5: A two-line command with address bit 0 set, or a four-line command with address bits [1:0] not equal to 0, is rejected.
- R6: A command with length code 2'b10 is rejected.
- R7: Byte access with a length code other than 2'b00 is rejected. Byte access with length code 2'b00 gives a single header that has bit 70 = 1 and carries the byte offset and byte count.
- R8: In line access, header bits [79:74] and [63:58] are 0, whatever values arrive on the byte offset and byte count inputs.
- R9: A request type other than 4'h0, 4'h1 or 4'h2 is rejected.
- R10: While `hdr_valid` is 1 and `hdr_ready` is 0, `hdr_data` and `hdr_valid` hold their values. `cmd_ready` is 0 whenever `hdr_valid` is 1.
- R11: A rejected command produces no header. It makes `cmd_err` 1 for exactly the one cycle after acceptance, and `cmd_ready` is 0 during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_addr | input | 42 | Base line address (byte address / 64) |
| cmd_len | input | 2 | Length code: 00 one line, 01 two, 11 four |
| cmd_type | input | 4 | Write request type |
| cmd_vc | input | 2 | Virtual channel |
| cmd_mdata | input | 16 | Metadata tag |
| cmd_byte_mode | input | 1 | 1 selects byte access |
| cmd_byte_start | input | 6 | Byte offset for byte access |
| cmd_byte_len | input | 6 | Byte count for byte access |
| hdr_valid | output | 1 | Header presented |
| hdr_ready | input | 1 | Downstream takes header |
| hdr_data | output | 80 | Header |
| cmd_err | output | 1 | One-cycle pulse for a rejected command |

## Verification
A wrong beat counter shows up in the first header after the fault. It gives a wrong [17:16] value, a reduced header where a full one belongs, or a missing or extra header. The scoreboard flags any of these on the next hand-off. Corrupted captured command fields appear in the first header of the same command. A stuck busy state shows immediately as `cmd_ready` staying low, and the bench reports it through a drain timeout. A faulty validity check is caught one cycle after acceptance, because headers appear where an error pulse was expected, or the reverse.

// File: rtl/wr_hdr_seq.sv
module wr_hdr_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [41:0] cmd_addr,
  input  logic [1:0]  cmd_len,
  input  logic [3:0]  cmd_type,
  input  logic [1:0]  cmd_vc,
  input  logic [15:0] cmd_mdata,
  input  logic        cmd_byte_mode,
  input  logic [5:0]  cmd_byte_start,
  input  logic [5:0]  cmd_byte_len,
  output logic        hdr_valid,
  input  logic        hdr_ready,
  output logic [79:0] hdr_data,
  output logic        cmd_err
);
  localparam logic [1:0] LEN_ONE  = 2'b00;
  localparam logic [1:0] LEN_TWO  = 2'b01;
  localparam logic [1:0] LEN_FOUR = 2'b11;
  localparam logic [3:0] TYPE_MAX = 4'h2;

  logic        busy, err_q;
  logic [1:0]  beat;
  logic [41:0] addr_q;
  logic [1:0]  len_q, vc_q;
  logic [3:0]  type_q;
  logic [15:0] md_q;
  logic        bmode_q;
  logic [5:0]  bstart_q, blen_q;

  wire take      = cmd_valid && cmd_ready;
  wire bad_align = (cmd_len == LEN_TWO && cmd_addr[0]) ||
                   (cmd_len == LEN_FOUR && cmd_addr[1:0] != 2'b00);
  wire bad_len   = cmd_len == 2'b10;
  wire bad_mode  = cmd_byte_mode && cmd_len != LEN_ONE;
  wire bad_type  = cmd_type > TYPE_MAX;
  wire bad       = bad_align || bad_len || bad_mode || bad_type;
  // legal length codes 00/01/11 equal the index of the final beat
  wire last_beat = beat == len_q;

  assign cmd_ready = !busy && !err_q;
  assign hdr_valid = busy;
  assign cmd_err   = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      err_q    <= 1'b0;
      beat     <= '0;
      addr_q   <= '0;
      len_q    <= '0;
      vc_q     <= '0;
      type_q   <= '0;
      md_q     <= '0;
      bmode_q  <= 1'b0;
      bstart_q <= '0;
      blen_q   <= '0;
    end else begin
      err_q <= take && bad;
      if (take && !bad) begin
        busy     <= 1'b1;
        beat     <= '0;
        addr_q   <= cmd_addr;
        len_q    <= cmd_len;
        vc_q     <= cmd_vc;
        type_q   <= cmd_type;
        md_q     <= cmd_mdata;
        bmode_q  <= cmd_byte_mode;
        bstart_q <= cmd_byte_mode ? cmd_byte_start : 6'd0;
        blen_q   <= cmd_byte_mode ? cmd_byte_len : 6'd0;
      end else if (busy && hdr_ready) begin
        if (last_beat) busy <= 1'b0;
        else           beat <= beat + 2'd1;
      end
    end
  end

  always_comb begin
    hdr_data = '0;
    if (busy) begin
      hdr_data[67:64] = type_q;
      if (beat == 2'd0) begin
        hdr_data[79:74] = blen_q;
        hdr_data[73:72] = vc_q;
        hdr_data[71]    = 1'b1;
        hdr_data[70]    = bmode_q;
        hdr_data[69:68] = len_q;
        hdr_data[63:58] = bstart_q;
        hdr_data[57:16] = addr_q;
        hdr_data[15:0]  = md_q;
      end else begin
        hdr_data[17:16] = addr_q[1:0] + beat;
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && !hdr_ready |=> hdr_valid && $stable(hdr_data)); // R10
  AST_CMD_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> !cmd_ready); // R10
  AST_REDUCED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && !hdr_data[71] |-> hdr_data[79:68] == 12'd0 && hdr_data[63:18] == 46'd0 && hdr_data[15:0] == 16'd0); // R4
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> !cmd_err); // R11
  AST_ERR_NO_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> !hdr_valid && !cmd_ready); // R11
  AST_TYPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> hdr_data[67:64] <= 4'h2); // R9
  AST_LINE_BYTES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_data[71] && !hdr_data[70] |-> hdr_data[79:74] == 6'd0 && hdr_data[63:58] == 6'd0); // R8
  AST_BYTE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_data[71] && hdr_data[70] |-> hdr_data[69:68] == 2'b00); // R7
  AST_FIRST_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && !bad |=> hdr_valid && hdr_data[71]); // R2
endmodule

// File: tb/sim_wr_hdr_seq.sv
module sim_wr_hdr_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [41:0] cmd_addr = '0;
  logic [1:0] cmd_len = '0, cmd_vc = '0;
  logic [3:0] cmd_type = '0;
  logic [15:0] cmd_mdata = '0;
  logic cmd_byte_mode = 1'b0;
  logic [5:0] cmd_byte_start = '0, cmd_byte_len = '0;
  logic hdr_valid, hdr_ready = 1'b0, cmd_err;
  logic [79:0] hdr_data;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [79:0] exp_q[$];
  string tag_q[$];
  logic prev_stall = 1'b0;
  logic [79:0] prev_data = '0;
  logic stall_mode = 1'b0;

  always #5 clk = ~clk;

  wr_hdr_seq u0 (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_type(cmd_type), .cmd_vc(cmd_vc),
    .cmd_mdata(cmd_mdata), .cmd_byte_mode(cmd_byte_mode), .cmd_byte_start(cmd_byte_start),
    .cmd_byte_len(cmd_byte_len), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_data(hdr_data), .cmd_err(cmd_err));

  task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        check(1'b0, "watchdog", 80'd0, 80'd1);
        finish_run();
      end
      #2 hdr_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(hdr_valid && hdr_data == prev_data, "R10 stall hold", hdr_data, prev_data);
      if (hdr_valid)
        check(!cmd_ready, "R10 cmd closed while busy", {79'd0, cmd_ready}, 80'd0);
      if (hdr_valid && hdr_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11 unexpected header", hdr_data, 80'd0);
        end else begin
          logic [79:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(hdr_data == e, t, hdr_data, e);
        end
      end
      prev_stall = hdr_valid && !hdr_ready;
      prev_data = hdr_data;
    end
  end

  task automatic send(input logic [41:0] a, input logic [1:0] len, input logic [3:0] t,
                      input logic [1:0] vc, input logic [15:0] md, input logic bm,
                      input logic [5:0] bs, input logic [5:0] bl, input bit bad, input string req);
    int beats;
    @(negedge clk);
    cmd_addr = a; cmd_len = len; cmd_type = t; cmd_vc = vc; cmd_mdata = md;
    cmd_byte_mode = bm; cmd_byte_start = bs; cmd_byte_len = bl; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    if (!bad) begin
      beats = (len == 2'b00) ? 1 : (len == 2'b01) ? 2 : 4;
      for (int k = 0; k < beats; k++) begin
        logic [79:0] h;
        h = '0;
        h[67:64] = t;
        if (k == 0) begin
          h[79:74] = bm ? bl : 6'd0;
          h[73:72] = vc;
          h[71] = 1'b1;
          h[70] = bm;
          h[69:68] = len;
          h[63:58] = bm ? bs : 6'd0;
          h[57:16] = a;
          h[15:0] = md;
        end else begin
          h[17:16] = a[1:0] + 2'(k);
        end
        exp_q.push_back(h);
        tag_q.push_back($sformatf("%s beat %0d", req, k));
      end
    end
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    if (bad) begin
      @(negedge clk);
      check(cmd_err && !cmd_ready && !hdr_valid, {req, " R11 error pulse"},
            {77'd0, cmd_err, cmd_ready, hdr_valid}, 80'b100);
      @(negedge clk);
      check(!cmd_err && !hdr_valid && cmd_ready, {req, " R11 pulse ends, no header"},
            {77'd0, cmd_err, cmd_ready, hdr_valid}, 80'b010);
    end
  endtask

  task automatic drain(input string req);
    int w = 0;
    while ((exp_q.size() != 0 || hdr_valid) && w < 200) begin
      @(negedge clk);
      w++;
    end
    check(exp_q.size() == 0 && !hdr_valid && cmd_ready, {req, " all headers taken, ready back"},
          {48'd0, 32'(exp_q.size())}, 80'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!hdr_valid && !cmd_err && cmd_ready, "R1 reset state",
          {77'd0, hdr_valid, cmd_err, cmd_ready}, 80'b001);

    send(42'h1234_5678, 2'b00, 4'h0, 2'b10, 16'hBEEF, 1'b0, 6'h2A, 6'h15, 1'b0, "R3 R8 single line");
    drain("R2");
    send(42'h3FF_0000_0004, 2'b01, 4'h1, 2'b01, 16'h0001, 1'b0, 6'h0, 6'h0, 1'b0, "R2 R4 two lines");
    drain("R2");
    send(42'h0000_0102, 2'b01, 4'h2, 2'b11, 16'hA5A5, 1'b0, 6'h3F, 6'h3F, 1'b0, "R4 two lines offset 2");
    drain("R2");
    send(42'h0ABC_DEF0, 2'b11, 4'h2, 2'b00, 16'h7777, 1'b0, 6'h0, 6'h0, 1'b0, "R2 R4 four lines");
    send(42'h0000_0008, 2'b11, 4'h0, 2'b10, 16'h1357, 1'b0, 6'h0, 6'h0, 1'b0, "R2 back-to-back four");
    drain("R2");

    stall_mode = 1'b1;
    send(42'h2_0000_000C, 2'b11, 4'h1, 2'b01, 16'hC0DE, 1'b0, 6'h11, 6'h22, 1'b0, "R10 four lines stalled");
    send(42'h0000_0040, 2'b00, 4'h1, 2'b11, 16'hFACE, 1'b1, 6'h05, 6'h30, 1'b0, "R7 byte access stalled");
    drain("R10");
    stall_mode = 1'b0;

    send(42'h0000_0003, 2'b01, 4'h0, 2'b00, 16'h0, 1'b0, 6'h0, 6'h0, 1'b1, "R5 two-line odd");
    send(42'h0000_0006, 2'b11, 4'h0, 2'b00, 16'h0, 1'b0, 6'h0, 6'h0, 1'b1, "R5 four-line low bits 10");
    send(42'h0000_0000, 2'b10, 4'h0, 2'b00, 16'h0, 1'b0, 6'h0, 6'h0, 1'b1, "R6 length code 10");
    send(42'h0000_0000, 2'b01, 4'h0, 2'b00, 16'h0, 1'b1, 6'h1, 6'h1, 1'b1, "R7 byte with two lines");
    send(42'h0000_0010, 2'b00, 4'h4, 2'b00, 16'h0, 1'b0, 6'h0, 6'h0, 1'b1, "R9 type 4");
    send(42'h0000_0010, 2'b00, 4'hF, 2'b00, 16'h0, 1'b0, 6'h0, 6'h0, 1'b1, "R9 type F");
    send(42'h0000_0020, 2'b01, 4'h0, 2'b10, 16'h4242, 1'b0, 6'h0, 6'h0, 1'b0, "R2 legal after rejects");
    drain("R11");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule